// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block is a synchronous finite-state machine that follows a processor core through its power states. The states are Normal, Auto Halt, Quick Start, Snoop Service and Deep Sleep. It takes the system's stop-clock request, the deep-sleep request, the bus-clock-running indication, the core's halt indication, the core reset, the snoop and bus-quiet strobes, the bus-priority request, and the interrupt and cache-flush requests. From these it produces a registered state code, a core clock enable, a PLL relock wait indicator, a snoop grant, acknowledges for interrupts and flushes, a core re-initialisation pulse and an illegal-activity flag.

Deep Sleep is entered from Quick Start by one of two causes: the bus clock stops, or the deep-sleep request rises. Deep Sleep is left when that cause goes away. A counter of `LOCK_CYCLES` cycles stands in for the PLL relock time before the machine returns to Quick Start. A snoop that arrives during Auto Halt or Quick Start moves the machine into Snoop Service. The machine remembers the state it came from and goes back there once the bus is quiet. The input restrictions of Quick Start stay in force during that detour.

Top module: `pwr_state_seq`

## Requirements
- R1: After the block reset `rst_n` is released, `state_o` is 0 (Normal) and `core_clk_en` is 1. All of `pll_wait`, `snoop_grant`, `illegal_act`, `core_init`, `irq_ack` and `flush_ack` are 0. The state codes are Normal=0, Auto Halt=1, Quick Start=2, Snoop Service=3 and Deep Sleep=4.
- R2: From Normal, `stop_req` moves the machine to Quick Start at the next edge; otherwise `halt_ind` moves it to Auto Halt. From Auto Halt, `stop_req` moves it to Quick Start; otherwise, when `halt_ind` is low, it returns to Normal.
- R3: `core_clk_en` is 0 in Quick Start and Deep Sleep, and 1 in the other three states.
- R4: Quick Start goes to Normal only at an edge where `stop_req` is low and no snoop is present.
- R5: Deep Sleep is entered only from Quick Start. It is entered when exactly one cause is active: `bclk_run` low, or `dsleep_req` high. When both causes are active in Quick Start, the machine stays in Quick Start and `illegal_act` is 1 for the following cycle.
- R6: In Deep Sleep, the wake condition is `bclk_run` high with `dsleep_req` low. The edge that first samples wake raises `pll_wait`, and `pll_wait` stays 1 for `LOCK_CYCLES` cycles. The state becomes Quick Start at the `LOCK_CYCLES`-th edge after that first edge, and `pll_wait` falls at that same edge.
- R7: A `snoop_req` sampled in Auto Halt or Quick Start moves the machine to Snoop Service. The machine stays there until `bus_quiet` is sampled high, then returns to its origin state. `snoop_grant` is 1 in Snoop Service while `bpri_req` was low at the previous edge.
- R8: In Quick Start, or in Snoop Service entered from Quick Start, a change on `halt_ind`, `irq_req` or `flush_req` sets `illegal_act` for one cycle. The same changes raise no flag in Snoop Service entered from Auto Halt.
- R9: `core_init` repeats `core_reset` one cycle later. A core reset during Quick Start leaves the state in Quick Start while `stop_req` is high. A core reset during Auto Halt, with `stop_req` low, returns the machine to Normal.
- R10: `irq_req` and `flush_req` produce a one-cycle `irq_ack` or `flush_ack` only when sampled in Normal or Auto Halt. They are never acknowledged in Quick Start, Snoop Service or Deep Sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low block reset |
| stop_req | input | 1 | Stop-clock request |
| dsleep_req | input | 1 | Deep-sleep request |
| bclk_run | input | 1 | Bus clock running indication |
| halt_ind | input | 1 | Core halted indication |
| core_reset | input | 1 | Core reset request |
| snoop_req | input | 1 | Snoop present on the bus |
| bus_quiet | input | 1 | Snoop serviced and bus idle |
| bpri_req | input | 1 | Priority agent bus request |
| irq_req | input | 1 | Interrupt request |
| flush_req | input | 1 | Cache flush request |
| state_o | output | 3 | Current state code |
| core_clk_en | output | 1 | Core clock enable |
| pll_wait | output | 1 | PLL relock in progress |
| snoop_grant | output | 1 | Snoop service grant |
| illegal_act | output | 1 | Illegal input activity flag |
| core_init | output | 1 | Core re-initialisation pulse |
| irq_ack | output | 1 | Interrupt accepted |
| flush_ack | output | 1 | Flush accepted |

## Verification
Every output comes from a register. The transitions, acknowledges, grant, flag and `core_init` therefore all appear exactly one edge after the inputs that cause them are sampled. The bench drives inputs at the falling edge and reads outputs at the next falling edge. The exception is the Deep Sleep exit. There the bench counts `LOCK_CYCLES` edges after the first edge that sees the wake condition, and checks `pll_wait` and the state at each of them. Both Deep Sleep entry causes are swept through the same entry and exit loop.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL = 3'd0,
        ST_AHALT  = 3'd1,
        ST_QSTART = 3'd2,
        ST_SNOOP  = 3'd3,
        ST_DSLEEP = 3'd4
    } pstate_e;

    typedef struct packed {
        pstate_e st;
        pstate_e ret;
        logic    illegal;
        logic    core_init;
        logic    irq_ack;
        logic    flush_ack;
        logic    grant;
    } seq_t;

endpackage

// File: rtl/pwr_lock_timer.sv
module pwr_lock_timer #(
    parameter int unsigned LOCK_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = $clog2(LOCK_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(LOCK_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

endmodule

// File: rtl/pwr_input_mon.sv
module pwr_input_mon #(
    parameter int unsigned N_MON = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MON-1:0] sample_i,
    output logic             changed_o
);
    logic [N_MON-1:0] prev_d, prev_q;
    logic [N_MON-1:0] diff;

    for (genvar i = 0; i < N_MON; i++) begin : g_bit
        assign diff[i] = sample_i[i] ^ prev_q[i];
    end

    always_comb begin
        prev_d = sample_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign changed_o = |diff;

endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
    import pwr_seq_pkg::*;
#(
    parameter int unsigned LOCK_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       dsleep_req,
    input  logic       bclk_run,
    input  logic       halt_ind,
    input  logic       core_reset,
    input  logic       snoop_req,
    input  logic       bus_quiet,
    input  logic       bpri_req,
    input  logic       irq_req,
    input  logic       flush_req,
    output logic [2:0] state_o,
    output logic       core_clk_en,
    output logic       pll_wait,
    output logic       snoop_grant,
    output logic       illegal_act,
    output logic       core_init,
    output logic       irq_ack,
    output logic       flush_ack
);
    localparam int unsigned N_MON = 3;

    seq_t q, d;

    logic lock_start, lock_busy, lock_done;
    logic mon_changed;
    logic restricted;
    logic cause_clk, cause_pin, cause_both, wake;

    pwr_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .start (lock_start),
        .busy  (lock_busy),
        .done  (lock_done)
    );

    pwr_input_mon #(.N_MON(N_MON)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_i  ({flush_req, irq_req, halt_ind}),
        .changed_o (mon_changed)
    );

    always_comb begin
        d          = q;
        d.illegal  = 1'b0;
        d.core_init = core_reset;
        d.irq_ack  = 1'b0;
        d.flush_ack = 1'b0;
        lock_start = 1'b0;

        restricted = (q.st == ST_QSTART) || (q.st == ST_SNOOP && q.ret == ST_QSTART);
        cause_clk  = !bclk_run;
        cause_pin  = dsleep_req;
        cause_both = cause_clk && cause_pin;
        wake       = !cause_clk && !cause_pin;

        case (q.st)
            ST_NORMAL: begin
                d.irq_ack   = irq_req;
                d.flush_ack = flush_req;
                if (stop_req) begin
                    d.st = ST_QSTART;
                end else if (halt_ind) begin
                    d.st = ST_AHALT;
                end
            end
            ST_AHALT: begin
                d.irq_ack   = irq_req;
                d.flush_ack = flush_req;
                if (stop_req) begin
                    d.st = ST_QSTART;
                end else if (core_reset) begin
                    d.st = ST_NORMAL;
                end else if (snoop_req) begin
                    d.st  = ST_SNOOP;
                    d.ret = ST_AHALT;
                end else if (!halt_ind) begin
                    d.st = ST_NORMAL;
                end
            end
            ST_QSTART: begin
                if (snoop_req) begin
                    d.st  = ST_SNOOP;
                    d.ret = ST_QSTART;
                end else if (!stop_req) begin
                    d.st = ST_NORMAL;
                end else if (cause_clk ^ cause_pin) begin
                    d.st = ST_DSLEEP;
                end
            end
            ST_SNOOP: begin
                if (bus_quiet) begin
                    d.st = q.ret;
                end
            end
            ST_DSLEEP: begin
                if (lock_done) begin
                    d.st = ST_QSTART;
                end else if (wake && !lock_busy) begin
                    lock_start = 1'b1;
                end
            end
            default: begin
                d.st = ST_NORMAL;
            end
        endcase

        d.illegal = (restricted && mon_changed) ||
                    (cause_both && (q.st == ST_QSTART || q.st == ST_DSLEEP));
        d.grant   = (d.st == ST_SNOOP) && !bpri_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= ST_NORMAL;
            q.ret       <= ST_NORMAL;
            q.illegal   <= 1'b0;
            q.core_init <= 1'b0;
            q.irq_ack   <= 1'b0;
            q.flush_ack <= 1'b0;
            q.grant     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign state_o     = q.st;
    assign core_clk_en = !(q.st == ST_QSTART || q.st == ST_DSLEEP);
    assign pll_wait    = lock_busy;
    assign snoop_grant = q.grant;
    assign illegal_act = q.illegal;
    assign core_init   = q.core_init;
    assign irq_ack     = q.irq_ack;
    assign flush_ack   = q.flush_ack;

endmodule

// File: rtl/pwr_state_seq_chk.sv
module pwr_state_seq_chk
    import pwr_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       stop_req,
    input logic [2:0] state_o,
    input logic       pll_wait,
    input logic       snoop_grant,
    input logic       irq_ack,
    input logic       flush_ack
);

    a_r6_wait_only_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        pll_wait |-> state_o == ST_DSLEEP);

    a_r6_sleep_exits_to_qs: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == ST_DSLEEP |=> (state_o == ST_DSLEEP || state_o == ST_QSTART));

    a_r5_sleep_only_from_qs: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != ST_DSLEEP && state_o != ST_QSTART) |=> state_o != ST_DSLEEP);

    a_r4_qs_holds_while_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_QSTART && stop_req) |=> state_o != ST_NORMAL);

    a_r7_grant_only_in_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_grant |-> state_o == ST_SNOOP);

    a_r10_no_ack_after_qs: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == ST_QSTART |=> (!irq_ack && !flush_ack));

endmodule

bind pwr_state_seq pwr_state_seq_chk u_chk (.*);

// File: tb/pwr_state_seq_tb_top.sv
module pwr_state_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LOCK = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 0, dsleep_req = 0, bclk_run = 1, halt_ind = 0, core_reset = 0;
    logic snoop_req = 0, bus_quiet = 0, bpri_req = 0, irq_req = 0, flush_req = 0;
    logic [2:0] state_o;
    logic core_clk_en, pll_wait, snoop_grant, illegal_act, core_init, irq_ack, flush_ack;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwr_state_seq #(.LOCK_CYCLES(LOCK)) dut_i (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .dsleep_req(dsleep_req),
        .bclk_run(bclk_run), .halt_ind(halt_ind), .core_reset(core_reset),
        .snoop_req(snoop_req), .bus_quiet(bus_quiet), .bpri_req(bpri_req),
        .irq_req(irq_req), .flush_req(flush_req), .state_o(state_o),
        .core_clk_en(core_clk_en), .pll_wait(pll_wait), .snoop_grant(snoop_grant),
        .illegal_act(illegal_act), .core_init(core_init), .irq_ack(irq_ack),
        .flush_ack(flush_ack)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 state", state_o, 0);
        chk("R1 clk_en", core_clk_en, 1);
        chk("R1 outputs", {pll_wait, snoop_grant, illegal_act, core_init, irq_ack, flush_ack}, 0);

        // R2, R3, R4: Normal -> Quick Start -> Normal
        stop_req = 1; tick();
        chk("R2 normal to qs", state_o, 2);
        chk("R3 clk_en qs", core_clk_en, 0);
        stop_req = 0; tick();
        chk("R4 qs to normal", state_o, 0);

        // R2 Auto Halt, R7 snoop from halt
        halt_ind = 1; tick();
        chk("R2 normal to halt", state_o, 1);
        chk("R3 clk_en halt", core_clk_en, 1);
        snoop_req = 1; tick();
        chk("R7 halt to snoop", state_o, 3);
        chk("R7 grant", snoop_grant, 1);
        chk("R3 clk_en snoop", core_clk_en, 1);
        snoop_req = 0; irq_req = 1; tick();
        chk("R8 no flag snoop from halt", illegal_act, 0);
        chk("R10 no irq ack in snoop", irq_ack, 0);
        chk("R7 stays without quiet", state_o, 3);
        irq_req = 0; bpri_req = 1; tick();
        chk("R7 grant withheld by bpri", snoop_grant, 0);
        bpri_req = 0; bus_quiet = 1; tick();
        chk("R7 return to halt", state_o, 1);
        bus_quiet = 0;
        halt_ind = 0; tick();
        chk("R2 halt to normal", state_o, 0);

        // R10 acknowledges in Normal
        irq_req = 1; tick();
        chk("R10 irq ack normal", irq_ack, 1);
        irq_req = 0; flush_req = 1; tick();
        chk("R10 irq ack drops", irq_ack, 0);
        chk("R10 flush ack normal", flush_ack, 1);
        flush_req = 0; tick();

        // R8 restrictions in Quick Start
        stop_req = 1; tick();
        chk("R2 enter qs", state_o, 2);
        halt_ind = 1; tick();
        chk("R8 halt change flag", illegal_act, 1);
        chk("R8 state kept", state_o, 2);
        tick();
        chk("R8 flag one cycle", illegal_act, 0);
        halt_ind = 0; irq_req = 1; tick();
        chk("R8 irq change flag", illegal_act, 1);
        chk("R10 no irq ack qs", irq_ack, 0);
        irq_req = 0; flush_req = 1; tick();
        chk("R10 no flush ack qs", flush_ack, 0);
        flush_req = 0; tick(); tick();
        chk("R8 quiet inputs no flag", illegal_act, 0);

        // R9 core reset in Quick Start
        core_reset = 1; tick();
        chk("R9 core_init", core_init, 1);
        chk("R9 stays qs", state_o, 2);
        core_reset = 0; tick();
        chk("R9 core_init drops", core_init, 0);
        chk("R9 still qs", state_o, 2);

        // R5 both causes together
        bclk_run = 0; dsleep_req = 1; tick();
        chk("R5 both causes stay qs", state_o, 2);
        chk("R5 both causes flag", illegal_act, 1);
        bclk_run = 1; dsleep_req = 0; tick();
        chk("R5 flag clears", illegal_act, 0);

        // R5, R6 sweep both entry causes
        for (int m = 0; m < 2; m++) begin
            if (m == 0) bclk_run = 0; else dsleep_req = 1;
            tick();
            chk("R5 enter deep sleep", state_o, 4);
            chk("R3 clk_en deep sleep", core_clk_en, 0);
            chk("R6 no wait before wake", pll_wait, 0);
            tick();
            chk("R6 holds while cause", state_o, 4);
            bclk_run = 1; dsleep_req = 0;
            for (int k = 0; k < LOCK; k++) begin
                tick();
                chk("R6 lock wait", pll_wait, 1);
                chk("R6 still deep sleep", state_o, 4);
            end
            tick();
            chk("R6 back to qs", state_o, 2);
            chk("R6 wait done", pll_wait, 0);
        end

        // R7, R8 snoop from Quick Start
        snoop_req = 1; tick();
        chk("R7 qs to snoop", state_o, 3);
        snoop_req = 0; halt_ind = 1; tick();
        chk("R8 flag in snoop from qs", illegal_act, 1);
        halt_ind = 0; bus_quiet = 1; tick();
        chk("R7 return to qs", state_o, 2);
        bus_quiet = 0; stop_req = 0; tick();
        chk("R4 release to normal", state_o, 0);

        // R9 core reset in Auto Halt
        halt_ind = 1; tick();
        chk("R9 in halt", state_o, 1);
        core_reset = 1; tick();
        chk("R9 halt reset to normal", state_o, 0);
        chk("R9 core_init halt", core_init, 1);
        core_reset = 0; halt_ind = 0; tick();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule